// File: doc/BRIEF.md
# Traffic-Driven Clock Level Controller

This controller decides how fast the core of a packet forwarding pipeline should run. It adds up the bytes that arrive at the receive queues and the bytes dropped at the output queues over fixed sampling windows. At the end of each window it chooses one of five clock levels. Each level is the constant 125 MHz source divided by 16, 8, 4, 2 or 1.

Three policies are available:
- A single-threshold policy, which always picks the smallest level whose capacity covers the traffic.
- A hysteresis policy with a low and a high band, which avoids switching back and forth when the load sits near a boundary.
- A loss-driven policy, which climbs one level whenever any byte was dropped and otherwise only scales down.

The controller runs entirely in the 125 MHz domain. It presents a level select, a one-cycle change strobe and the totals of the last window. Clock generation and glitch-free switching belong to a separate block.

Top module: `freq_scale_ctrl`

## Requirements
- R1: After reset, `level_o` is 4, `change_o` is 0, both window totals read 0 and the policy is single-threshold. Level code n stands for state S(n+1): 0 is S1 (source divided by 16) and 4 is S5 (undivided).
- R2: A window is WIN clock edges long. Its received and dropped totals include the increments sampled at every edge of the window, including the last one. The totals appear on `last_rx_o` and `last_drop_o` from the cycle after the window's final edge, and the count then restarts from zero.
- R3: A window total that would exceed 2^CW-1 holds at 2^CW-1 instead of wrapping.
- R4: `level_o` changes only on the final edge of a window. `change_o` is high for exactly the one cycle after an edge where the level changed, and is low at all other times.
- R5: Under policy code 00 (single-threshold), with received total c, the new level is the lowest level i whose high threshold H(i) is at or above c. If no such level exists, the new level is 4.
- R6: Under policy codes 01 and 11 (hysteresis) in level j, the level holds when the following two conditions are both true:
  - j is 0, or c is at or above L(j-1).
  - j is 4, or c is at or below H(j).
- R7: Under the hysteresis policy, when c is below L(j-1) or above H(j), the new level is the lowest level whose H is at or above c, or 4 if none is.
- R8: Under policy code 10 (loss-driven), a window with a nonzero dropped total raises the level by exactly one, up to a maximum of 4. This takes precedence over any scale-down.
- R9: Under the loss-driven policy, a window with no drops never raises the level. It lowers the level by the R7 rule when c is below L(j-1).
- R10: The policy register loads `pol_wdata_i` on an edge where `pol_we_i` is high, and the value in force at a window's final edge governs that window's decision. Under codes 00, 01 and 11 the dropped total has no effect on the level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Constant 125 MHz clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bytes_i | input | IW | Bytes received this cycle, summed over all receive queues |
| drop_bytes_i | input | IW | Bytes dropped this cycle, summed over all output queues |
| pol_we_i | input | 1 | Policy register write enable |
| pol_wdata_i | input | 2 | Policy code to write |
| policy_o | output | 2 | Policy register contents |
| level_o | output | 3 | Selected clock level, 0 slowest to 4 fastest |
| change_o | output | 1 | One-cycle strobe after a level change |
| last_rx_o | output | CW | Received total of the last completed window |
| last_drop_o | output | CW | Dropped total of the last completed window |

## Verification
Two functions can act on the same cycle: the end-of-window decision and the arrival of the window's last increments. The bench pushes the final bytes of each window into its last cycle. A comparison against the reported total and the chosen level shows whether those bytes were counted before the decision.

A loss event and a scale-down condition can also coincide. The bench pairs drops with received totals below the current low band. It expects the single-step rise to win.

A policy write can land inside the window it governs. The bench checks that the decision at that window's end follows the newly written code.

// File: rtl/freq_scale_ctrl.sv
module freq_scale_ctrl #(
  parameter int WIN = 1250000,
  parameter int IW  = 4,
  parameter int CW  = 24,
  parameter int H1 = 526000,  parameter int H2 = 1043000, parameter int H3 = 2036000,
  parameter int H4 = 4105000, parameter int H5 = 8190000,
  parameter int L1 = 471000,  parameter int L2 = 933000,  parameter int L3 = 1822000,
  parameter int L4 = 3673000, parameter int L5 = 7327000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rx_bytes_i,
  input  logic [IW-1:0] drop_bytes_i,
  input  logic          pol_we_i,
  input  logic [1:0]    pol_wdata_i,
  output logic [1:0]    policy_o,
  output logic [2:0]    level_o,
  output logic          change_o,
  output logic [CW-1:0] last_rx_o,
  output logic [CW-1:0] last_drop_o
);
  localparam int TW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic [TW-1:0] TLAST = TW'(WIN - 1);
  localparam logic [1:0] POL_SINGLE = 2'b00;
  localparam logic [1:0] POL_LOSS   = 2'b10;

  logic [TW-1:0] tick_q;
  logic [CW-1:0] rx_acc, drop_acc, rx_sum, drop_sum;
  logic [CW:0]   rx_wide, drop_wide;
  logic [2:0]    level_q, nxt, fit, below;
  logic [1:0]    pol_q;
  logic          change_q, win_end, under_lo, over_hi;
  logic [CW-1:0] hi [0:4];
  logic [CW-1:0] lo [0:4];

  assign hi[0] = CW'(H1);
  assign hi[1] = CW'(H2);
  assign hi[2] = CW'(H3);
  assign hi[3] = CW'(H4);
  assign hi[4] = CW'(H5);
  assign lo[0] = CW'(L1);
  assign lo[1] = CW'(L2);
  assign lo[2] = CW'(L3);
  assign lo[3] = CW'(L4);
  assign lo[4] = CW'(L5);

  assign win_end   = (tick_q == TLAST);
  assign rx_wide   = {1'b0, rx_acc}   + {{(CW + 1 - IW){1'b0}}, rx_bytes_i};
  assign drop_wide = {1'b0, drop_acc} + {{(CW + 1 - IW){1'b0}}, drop_bytes_i};
  assign rx_sum    = rx_wide[CW]   ? '1 : rx_wide[CW-1:0];
  assign drop_sum  = drop_wide[CW] ? '1 : drop_wide[CW-1:0];

  always_comb begin
    fit = 3'd4;
    for (int i = 4; i >= 0; i--)
      if (rx_sum <= hi[i]) fit = 3'(i);
  end

  assign below    = level_q - 3'd1;
  assign under_lo = (level_q != 3'd0) && (rx_sum < lo[below]);
  assign over_hi  = (level_q != 3'd4) && (rx_sum > hi[level_q]);

  always_comb begin
    nxt = level_q;
    if (pol_q == POL_SINGLE) begin
      nxt = fit;
    end else if (pol_q == POL_LOSS) begin
      if (drop_sum != '0) nxt = (level_q < 3'd4) ? level_q + 3'd1 : level_q;
      else if (under_lo)  nxt = fit;
    end else begin
      if (under_lo || over_hi) nxt = fit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_q    <= '0;
      rx_acc    <= '0;
      drop_acc  <= '0;
      last_rx_o <= '0;
      last_drop_o <= '0;
      level_q   <= 3'd4;
      change_q  <= 1'b0;
      pol_q     <= POL_SINGLE;
    end else begin
      if (pol_we_i) pol_q <= pol_wdata_i;
      change_q <= win_end && (nxt != level_q);
      if (win_end) begin
        tick_q      <= '0;
        rx_acc      <= '0;
        drop_acc    <= '0;
        last_rx_o   <= rx_sum;
        last_drop_o <= drop_sum;
        level_q     <= nxt;
      end else begin
        tick_q   <= tick_q + 1'b1;
        rx_acc   <= rx_sum;
        drop_acc <= drop_sum;
      end
    end
  end

  assign level_o  = level_q;
  assign change_o = change_q;
  assign policy_o = pol_q;

  p_level_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= 3'd4);
  p_strobe_matches_move_r4: assert property (@(posedge clk) disable iff (!rst_n)
    change_q == (level_q != $past(level_q)));
  p_hold_mid_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(level_q));
  p_loss_one_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && pol_q == POL_LOSS && drop_sum != '0 && level_q < 3'd4)
      |=> level_o == $past(level_q) + 3'd1);
  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> last_rx_o >= $past(rx_acc));
endmodule

// File: tb/freq_scale_ctrl_test.sv
module freq_scale_ctrl_test;
  localparam int W = 20;
  localparam int IW = 4;
  localparam int CW = 8;
  localparam int MAXV = 255;

  logic clk = 0, rst_n = 0;
  logic [IW-1:0] rx_bytes = 0, drop_bytes = 0;
  logic pol_we = 0;
  logic [1:0] pol_wdata = 0;
  logic [1:0] policy;
  logic [2:0] level;
  logic change;
  logic [CW-1:0] last_rx, last_drop;

  int H[5] = '{10, 25, 50, 100, 200};
  int L[5] = '{8, 21, 42, 85, 170};
  int checks = 0, fails = 0;
  int exp_lvl = 4;
  int cur_pol = 0;

  always #5 clk = ~clk;

  freq_scale_ctrl #(.WIN(W), .IW(IW), .CW(CW),
    .H1(10), .H2(25), .H3(50), .H4(100), .H5(200),
    .L1(8), .L2(21), .L3(42), .L4(85), .L5(170)) uut (
    .clk(clk), .rst_n(rst_n), .rx_bytes_i(rx_bytes), .drop_bytes_i(drop_bytes),
    .pol_we_i(pol_we), .pol_wdata_i(pol_wdata), .policy_o(policy),
    .level_o(level), .change_o(change), .last_rx_o(last_rx), .last_drop_o(last_drop));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int fit(int c);
    for (int i = 0; i < 5; i++) if (c <= H[i]) return i;
    return 4;
  endfunction

  function automatic int next_level(int l, int p, int c, int d);
    if (p == 0) return fit(c);
    if (p == 2) begin
      if (d > 0) return (l < 4) ? l + 1 : l;
      if (l > 0 && c < L[l-1]) return fit(c);
      return l;
    end
    if (l > 0 && c < L[l-1]) return fit(c);
    if (l < 4 && c > H[l]) return fit(c);
    return l;
  endfunction

  // Drives one window; the last bytes are pushed toward the final cycle.
  task automatic run_window(int c, int d, bit wr, int p);
    int rleft = c, dleft = d, prev = exp_lvl, cs, ds;
    if (wr) cur_pol = p;
    for (int i = 0; i < W; i++) begin
      int room = (W - 1 - i) * 15;
      int rv = (rleft > room) ? rleft - room : 0;
      int dv = (dleft > room) ? dleft - room : 0;
      if (rv > 15) rv = 15;
      if (dv > 15) dv = 15;
      rleft -= rv; dleft -= dv;
      rx_bytes = IW'(rv);
      drop_bytes = IW'(dv);
      pol_we = wr && (i == 0);
      pol_wdata = 2'(p);
      @(negedge clk);
      if (i == W / 2) begin
        check("R4 level held mid-window", level, prev);
        check("R4 no strobe mid-window", change, 0);
      end
    end
    cs = (c > MAXV) ? MAXV : c;
    ds = (d > MAXV) ? MAXV : d;
    exp_lvl = next_level(prev, cur_pol, cs, ds);
    check("R2 R3 received total", last_rx, cs);
    check("R2 R3 dropped total", last_drop, ds);
    check("R5 R6 R7 R8 R9 R10 level", level, exp_lvl);
    check("R4 change strobe", change, (exp_lvl != prev) ? 1 : 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset level", level, 4);
    check("R1 reset strobe", change, 0);
    check("R1 reset rx total", last_rx, 0);
    check("R1 reset drop total", last_drop, 0);
    check("R1 reset policy", policy, 0);
    rst_n = 1;
    for (int p = 0; p < 3; p++) begin
      for (int k = 0; k < 300; k++) begin
        int c = (k * 37 + p * 11) % 300;
        int d = (k % 4 == 0) ? (k % 3) + 1 : 0;
        run_window(c, d, k == 0, p);
      end
      check("R10 policy register", policy, p);
    end
    run_window(260, 280, 0, 2);
    for (int k = 0; k < 60; k++) run_window((k * 53) % 256, k % 2, k == 0, 3);
    check("R10 policy code 11", policy, 3);
    run_window(5, 0, 1, 1);
    run_window(5, 0, 0, 1);
    run_window(0, 4, 1, 2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule